// File: doc/BRIEF.md
# Power Partition Gating Controller

This block switches up to 32 power partitions on and off and controls the output isolation clamp of each partition. Software drives it through a small 32-bit register port with a write strobe and a combinational read. Four registers are decoded: a toggle command, a power status word, a clamp release command and a clamp status word.

A toggle command names one partition and, when its start bit is set, inverts that partition's power state. The controller raises or drops the partition's switch request. It then waits for the matching power-good acknowledge, for at most a programmable number of cycles. The start bit stays set while the operation runs. A clamp release command lifts the isolation clamp of a powered partition. Requests that cannot be honoured are dropped and raise a sticky error flag. A missing acknowledge raises a sticky timeout flag. All pins are plain level signals; there is no streaming data path and no back-pressure.

Top module: `pgate_ctrl`

## Requirements
- R1: After reset every partition is unpowered and clamped: `pwr_req` is 0, `clamp_en` is all ones, registers 0x30, 0x34 and 0x38 read 0, 0x2C reads 0xFFFFFFFF, and `err_flag` and `tmo_flag` are 0.
- R2: A write to offset 0x30 with bit 8 (start) set selects the partition given by bits 4:0. In the same clock edge that partition's `pwr_req` bit becomes the inverse of its current power status.
- R3: While a toggle is in progress, offset 0x30 reads bit 8 as 1 and bits 4:0 as the index. The status bit changes only once `pwr_ack` for that partition equals the request. Bit 8 then reads 0.
- R4: Offset 0x38 holds one bit per partition at the position of its index; 1 means powered.
- R5: Writing offset 0x34 with a bit set for a powered partition makes that bit read back as 1 for one cycle, then 0. From the following edge the partition's clamp status bit at 0x2C and its `clamp_en` are 0; 1 means clamped.
- R6: Command bit positions SWAP_A and SWAP_B (defaults 5 and 10) at 0x34 are exchanged: bit SWAP_B acts on partition SWAP_A and bit SWAP_A acts on partition SWAP_B. Clamp status bits are not exchanged.
- R7: A release bit that maps to an unpowered partition is ignored: its clamp stays set and `err_flag` becomes 1 and stays 1 until reset.
- R8: A toggle write with start set that arrives while a toggle is in progress is ignored, and `err_flag` is set.
- R9: If the acknowledge does not match within `ack_limit`+1 waiting cycles, start reads 0, `tmo_flag` becomes 1 (sticky), the status bit is unchanged and `pwr_req` returns to the status value.
- R10: A write to 0x30 with bit 8 clear has no effect on power request, status or the toggle register.
- R11: When a partition's power status falls to 0, its clamp is set again on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ack_limit | input | 16 | Acknowledge wait limit in cycles |
| pwr_req | output | 32 | Per-partition power switch request |
| pwr_ack | input | 32 | Per-partition power-good acknowledge |
| clamp_en | output | 32 | Per-partition isolation clamp enable |
| err_flag | output | 1 | Sticky refused-command flag |
| tmo_flag | output | 1 | Sticky acknowledge timeout flag |

## Verification
The assertions take for granted that `pwr_ack` only follows `pwr_req`. They also assume the register port is driven with stable values around the clock edge. A status change is therefore required to copy an earlier request, and a clamp may only lift on a partition that was powered. The stimulus models each partition's power switch as a three-cycle delay from request to acknowledge. A stuck mask holds chosen acknowledges fixed, which creates the timeout case. All register accesses change inputs on the falling clock edge.

// File: rtl/pgate_pkg.sv
package pgate_pkg;
  localparam logic [7:0] OFS_CLAMP   = 8'h2C;
  localparam logic [7:0] OFS_TOGGLE  = 8'h30;
  localparam logic [7:0] OFS_RELEASE = 8'h34;
  localparam logic [7:0] OFS_POWER   = 8'h38;
  localparam int START_BIT = 8;
  localparam int IDX_W     = 5;

  typedef enum logic {ST_IDLE, ST_WAIT} tog_st_t;

  // Release-command bit position to physical partition
  function automatic int cmd_to_part(input int j, input int a, input int b);
    if (j == a) return b;
    if (j == b) return a;
    return j;
  endfunction
endpackage

// File: rtl/pgate_toggle_fsm.sv
module pgate_toggle_fsm
  import pgate_pkg::*;
#(
  parameter int NPART = 32,
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic [LIM_W-1:0] ack_limit,
  input  logic [NPART-1:0] pwr_ack,
  output logic             busy,
  output logic [IDX_W-1:0] cur_idx,
  output logic [NPART-1:0] pwr_req,
  output logic [NPART-1:0] pwr_stat,
  output logic             refused,
  output logic             tmo_pulse
);
  tog_st_t          st;
  logic [LIM_W-1:0] cnt;
  logic             target;
  logic             ack_ok;
  logic             accept;

  assign busy    = (st == ST_WAIT);
  assign accept  = cmd_wr && !busy && (int'(cmd_idx) < NPART);
  assign refused = cmd_wr && busy;
  assign ack_ok  = (pwr_ack[cur_idx] == target);
  assign tmo_pulse = busy && !ack_ok && (cnt == ack_limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cur_idx  <= '0;
      cnt      <= '0;
      target   <= 1'b0;
      pwr_req  <= '0;
      pwr_stat <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            cur_idx          <= cmd_idx;
            target           <= ~pwr_stat[cmd_idx];
            pwr_req[cmd_idx] <= ~pwr_stat[cmd_idx];
            cnt              <= '0;
            st               <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (ack_ok) begin
            pwr_stat[cur_idx] <= target;
            st                <= ST_IDLE;
          end else if (cnt == ack_limit) begin
            pwr_req[cur_idx] <= pwr_stat[cur_idx];
            st               <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgate_clamp_unit.sv
module pgate_clamp_unit
  import pgate_pkg::*;
#(
  parameter int NPART  = 32,
  parameter int SWAP_A = 5,
  parameter int SWAP_B = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rel_wr,
  input  logic [NPART-1:0] rel_data,
  input  logic [NPART-1:0] pwr_stat,
  output logic [NPART-1:0] clamp_en,
  output logic [NPART-1:0] pend_cmd,
  output logic             refused
);
  logic [NPART-1:0] phys_req;
  logic [NPART-1:0] pend_phys;

  for (genvar j = 0; j < NPART; j++) begin : g_map
    localparam int P = cmd_to_part(j, SWAP_A, SWAP_B);
    assign phys_req[P] = rel_wr & rel_data[j];
    assign pend_cmd[j] = pend_phys[P];
  end

  assign refused = |(phys_req & ~pwr_stat);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_phys <= '0;
      clamp_en  <= '1;
    end else begin
      pend_phys <= phys_req & pwr_stat;
      clamp_en  <= (clamp_en & ~pend_phys) | ~pwr_stat;
    end
  end
endmodule

// File: rtl/pgate_rdmux.sv
module pgate_rdmux
  import pgate_pkg::*;
#(
  parameter int NPART = 32
) (
  input  logic [7:0]       addr,
  input  logic             busy,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic [NPART-1:0] clamp_en,
  input  logic [NPART-1:0] pend_cmd,
  input  logic [NPART-1:0] pwr_stat,
  output logic [31:0]      rdata
);
  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_CLAMP:   rdata[NPART-1:0] = clamp_en;
      OFS_RELEASE: rdata[NPART-1:0] = pend_cmd;
      OFS_POWER:   rdata[NPART-1:0] = pwr_stat;
      OFS_TOGGLE: begin
        rdata[START_BIT] = busy;
        if (busy) rdata[IDX_W-1:0] = cur_idx;
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pgate_ctrl.sv
module pgate_ctrl
  import pgate_pkg::*;
#(
  parameter int NPART  = 32,
  parameter int LIM_W  = 16,
  parameter int SWAP_A = 5,
  parameter int SWAP_B = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wen,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [LIM_W-1:0] ack_limit,
  output logic [NPART-1:0] pwr_req,
  input  logic [NPART-1:0] pwr_ack,
  output logic [NPART-1:0] clamp_en,
  output logic             err_flag,
  output logic             tmo_flag
);
  logic             tog_wr, rel_wr;
  logic             busy, tog_refused, rel_refused, tmo_pulse;
  logic [IDX_W-1:0] cur_idx;
  logic [NPART-1:0] pwr_stat, pend_cmd;

  assign tog_wr = reg_wen && (reg_addr == OFS_TOGGLE) && reg_wdata[START_BIT];
  assign rel_wr = reg_wen && (reg_addr == OFS_RELEASE);

  pgate_toggle_fsm #(.NPART(NPART), .LIM_W(LIM_W)) u_fsm (
    .clk(clk), .rst(rst), .cmd_wr(tog_wr), .cmd_idx(reg_wdata[IDX_W-1:0]),
    .ack_limit(ack_limit), .pwr_ack(pwr_ack), .busy(busy), .cur_idx(cur_idx),
    .pwr_req(pwr_req), .pwr_stat(pwr_stat), .refused(tog_refused),
    .tmo_pulse(tmo_pulse)
  );

  pgate_clamp_unit #(.NPART(NPART), .SWAP_A(SWAP_A), .SWAP_B(SWAP_B)) u_clamp (
    .clk(clk), .rst(rst), .rel_wr(rel_wr), .rel_data(reg_wdata[NPART-1:0]),
    .pwr_stat(pwr_stat), .clamp_en(clamp_en), .pend_cmd(pend_cmd),
    .refused(rel_refused)
  );

  pgate_rdmux #(.NPART(NPART)) u_rd (
    .addr(reg_addr), .busy(busy), .cur_idx(cur_idx), .clamp_en(clamp_en),
    .pend_cmd(pend_cmd), .pwr_stat(pwr_stat), .rdata(reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag <= 1'b0;
      tmo_flag <= 1'b0;
    end else begin
      err_flag <= err_flag | tog_refused | (rel_wr & rel_refused);
      tmo_flag <= tmo_flag | tmo_pulse;
    end
  end
endmodule

// File: rtl/pgate_ctrl_chk.sv
module pgate_ctrl_chk #(
  parameter int NPART = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [NPART-1:0] pwr_req,
  input logic [NPART-1:0] pwr_stat,
  input logic [NPART-1:0] clamp_en,
  input logic             busy,
  input logic             err_flag,
  input logic             tmo_flag
);
  // R3: status only ever moves to a value that was requested
  p_stat_follows_req_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(pwr_stat) |-> (pwr_stat == $past(pwr_req)));

  // R3: status changes only at the end of a running toggle
  p_stat_needs_busy_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(pwr_stat) |-> $past(busy));

  // R9: with no toggle running, request matches status
  p_req_settled_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (pwr_req == pwr_stat));

  // R7: a clamp lifts only on a powered partition
  p_release_powered_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(clamp_en) & ~clamp_en) & ~$past(pwr_stat)) == '0));

  // R11: an unpowered partition is clamped one edge later
  p_reclamp_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~$past(pwr_stat) & ~clamp_en) == '0));

  // R7 / R9: flags are sticky
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);
  p_tmo_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    tmo_flag |=> tmo_flag);
endmodule

bind pgate_ctrl pgate_ctrl_chk #(.NPART(NPART)) u_chk (
  .clk(clk), .rst(rst), .pwr_req(pwr_req), .pwr_stat(pwr_stat),
  .clamp_en(clamp_en), .busy(busy), .err_flag(err_flag), .tmo_flag(tmo_flag)
);

// File: tb/tb_pgate_ctrl.sv
module tb_pgate_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wen = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] ack_limit = 16'd8;
  logic [31:0] pwr_req, pwr_ack, clamp_en;
  logic        err_flag, tmo_flag;
  logic [31:0] d1, d2, stuck = '0;
  int checks = 0, failures = 0;
  logic [31:0] model, v;

  always #2 clk = ~clk;

  pgate_ctrl dut (
    .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack_limit(ack_limit),
    .pwr_req(pwr_req), .pwr_ack(pwr_ack), .clamp_en(clamp_en),
    .err_flag(err_flag), .tmo_flag(tmo_flag)
  );

  // power switch model: acknowledge follows request after three edges
  always_ff @(posedge clk) begin
    if (rst) begin
      d1 <= '0; d2 <= '0; pwr_ack <= '0;
    end else begin
      d1 <= pwr_req; d2 <= d1;
      pwr_ack <= (d2 & ~stuck) | (pwr_ack & stuck);
    end
  end

  // table entries: {expected status bit after toggle, index}
  localparam logic [5:0] TOG_TBL [9] = '{
    {1'b1,5'd3}, {1'b1,5'd0}, {1'b1,5'd31}, {1'b0,5'd3}, {1'b1,5'd17},
    {1'b1,5'd5}, {1'b1,5'd10}, {1'b0,5'd0}, {1'b0,5'd10}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] t;
    for (int i = 0; i < 60; i++) begin
      rd(8'h30, t);
      if (!t[8]) break;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; stuck = '0; ack_limit = 16'd8;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #150000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    rd(8'h38, v); check("R1 power status", v, 32'h0);
    rd(8'h2C, v); check("R1 clamp status", v, 32'hFFFFFFFF);
    rd(8'h30, v); check("R1 toggle reg", v, 32'h0);
    rd(8'h34, v); check("R1 release reg", v, 32'h0);
    check("R1 pwr_req", pwr_req, 32'h0);
    check("R1 clamp_en", clamp_en, 32'hFFFFFFFF);
    check("R1 flags", {30'd0, err_flag, tmo_flag}, 32'h0);

    // R10 toggle write without start ignored
    wr(8'h30, 32'h0000_0007);
    repeat (6) @(negedge clk);
    rd(8'h38, v); check("R10 status unchanged", v, 32'h0);
    rd(8'h30, v); check("R10 toggle reg", v, 32'h0);
    check("R10 pwr_req", pwr_req, 32'h0);

    // R2 R3 R4 table walk
    model = '0;
    foreach (TOG_TBL[k]) begin
      wr(8'h30, 32'h100 | {27'd0, TOG_TBL[k][4:0]});
      rd(8'h30, v); check("R3 busy readback", v, 32'h100 | {27'd0, TOG_TBL[k][4:0]});
      model[TOG_TBL[k][4:0]] = ~model[TOG_TBL[k][4:0]];
      check("R2 request", pwr_req, model);
      wait_idle();
      rd(8'h30, v); check("R3 start cleared", v & 32'h100, 32'h0);
      rd(8'h38, v);
      check("R4 status bit", {31'd0, v[TOG_TBL[k][4:0]]}, {31'd0, TOG_TBL[k][5]});
      check("R4 status word", v, model);
    end
    // status now partitions 31, 17, 5

    // R5 plain release on partition 31
    wr(8'h34, 32'h8000_0000);
    rd(8'h34, v); check("R5 release pending", v, 32'h8000_0000);
    @(negedge clk);
    rd(8'h34, v); check("R5 release self-clears", v, 32'h0);
    rd(8'h2C, v); check("R5 clamp status", v, 32'h7FFFFFFF);
    check("R5 clamp_en", clamp_en, 32'h7FFFFFFF);

    // R6 swapped bit: command bit 10 releases partition 5
    wr(8'h34, 32'h0000_0400);
    rd(8'h34, v); check("R6 pending in command position", v, 32'h0000_0400);
    @(negedge clk);
    rd(8'h2C, v); check("R6 clamp of partition 5 lifted", v, 32'h7FFFFFDF);
    check("R6 no error", {31'd0, err_flag}, 32'h0);

    // R7 command bit 5 maps to partition 10, unpowered
    wr(8'h34, 32'h0000_0020);
    @(negedge clk);
    rd(8'h2C, v); check("R7 clamp kept", v, 32'h7FFFFFDF);
    check("R7 err set", {31'd0, err_flag}, 32'h1);

    // R11 power-off re-clamps partition 5
    wr(8'h30, 32'h105);
    wait_idle();
    @(negedge clk);
    rd(8'h2C, v); check("R11 reclamp", v, 32'h7FFFFFFF);
    check("R11 clamp_en", clamp_en[5] ? 32'h1 : 32'h0, 32'h1);

    // R8 toggle while busy
    do_reset();
    wr(8'h30, 32'h104);
    wr(8'h30, 32'h106);
    wait_idle();
    rd(8'h38, v); check("R8 second toggle ignored", v, 32'h0000_0010);
    check("R8 err set", {31'd0, err_flag}, 32'h1);

    // R9 timeout
    do_reset();
    stuck = 32'h0000_0200; ack_limit = 16'd4;
    wr(8'h30, 32'h109);
    rd(8'h30, v); check("R9 busy", v, 32'h109);
    repeat (12) @(negedge clk);
    rd(8'h30, v); check("R9 start cleared", v & 32'h100, 32'h0);
    check("R9 tmo_flag", {31'd0, tmo_flag}, 32'h1);
    rd(8'h38, v); check("R9 status unchanged", v, 32'h0);
    check("R9 request reverted", pwr_req, 32'h0);
    check("R9 no err", {31'd0, err_flag}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule